// File: doc/BRIEF.md
# Lamp Ballast Phase Timer

This block steps a fluorescent lamp controller through its start-up phases by counting cycles of an external sawtooth timing oscillator. It waits in an idle phase until the supply is up and the timing pin has charged past its upper threshold. It then counts a fixed number of sawtooth cycles of filament preheat and opens a short window in which the lamp must strike. After a strike it runs a boost phase of fixed length and then settles into burn. A lamp that fails to strike, or an overcurrent that persists too long, drives the block into a power-down phase with a latched fault flag. Only a synchronous reset releases that phase.

The oscillator, the comparators and the half-bridge driver sit outside the block. They appear as single-bit inputs sampled on the system clock. `saw_cycle` pulses for one clock at the end of each full sawtooth cycle. `saw_half` pulses for one clock at each half-cycle point. One cycle counter serves every phase and is cleared on each phase change. A separate low-order overcurrent field counts half-cycle marks only while the overcurrent flag stays high, so the overcurrent window is longer than half a sawtooth cycle. A parameter chooses whether the overcurrent window is also armed during boost. All outputs are registered.

Top module: `lamp_phase_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters phase code 0 (idle) and clears `preheat_done`, `ign_fail` and `oc_fault` after that edge.
- R2: In idle, the phase leaves 0 only on an edge where `supply_ok` and `pin_high` are both high, and moves to 1 (preheat). `saw_cycle` pulses seen in idle do not count toward preheat.
- R3: Preheat ends on the edge that samples the PRE_CYC-th `saw_cycle` pulse (default 8). The phase becomes 2 (ignite) and `preheat_done` is high for exactly the one following cycle.
- R4: In ignite, `lamp_lit` high at an edge moves the phase to 3 (boost). This holds even when the same edge samples the last allowed `saw_cycle` pulse.
- R5: If the IGN_CYC-th `saw_cycle` pulse in ignite (default 2) arrives without `lamp_lit`, the phase becomes 5 (power-down) and `ign_fail` is set.
- R6: Boost ends on the edge that samples its BOOST_CYC-th `saw_cycle` pulse (default 4), and the phase becomes 4 (burn).
- R7: In burn, OC_HALVES consecutive `saw_half` pulses (default 2) sampled while `oc_cont` stays high move the phase to 5 and set `oc_fault`. `saw_half` pulses with `oc_cont` low have no effect.
- R8: A cycle with `oc_cont` low resets the overcurrent count to zero, so a later overcurrent needs the full OC_HALVES half-cycle marks again.
- R9: Phase 5 and both fault flags hold under any input pattern until `rst` is asserted.
- R10: Every phase change clears the counts. Ignite gets a full IGN_CYC pulses after preheat, and an overcurrent count built up in boost does not carry into burn.
- R11: With OC_IN_BOOST=1 (default), the overcurrent window of R7 also applies in boost and ends it in phase 5 with `oc_fault` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| saw_cycle | input | 1 | One-clock pulse at the end of each sawtooth cycle |
| saw_half | input | 1 | One-clock pulse at each half-cycle point of the sawtooth |
| supply_ok | input | 1 | Supply has reached its start level |
| pin_high | input | 1 | Timing pin is above its upper threshold |
| lamp_lit | input | 1 | Lamp has struck |
| oc_cont | input | 1 | Overcurrent is present continuously |
| phase | output | 3 | Phase code: 0 idle, 1 preheat, 2 ignite, 3 boost, 4 burn, 5 power-down |
| preheat_done | output | 1 | One-cycle strobe when preheat completes |
| ign_fail | output | 1 | Latched ignition-failure fault |
| oc_fault | output | 1 | Latched overcurrent fault |

## Verification
Every result is due one clock after the edge that samples its cause: the phase change, the `preheat_done` strobe and either fault flag all appear after that single register stage. The driver sets each stimulus on a falling edge and queues the expected output at the same moment. The monitor pops that entry shortly after the next rising edge, which is the first point where the registered response is visible. Stimuli that must have no effect, such as idle pulses, lone half-cycle marks and inputs applied in power-down, get their own queued entry for the same cycle, so a missed effect shows up in the very cycle it would have occurred.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

   typedef enum logic [2:0] {
      PH_IDLE    = 3'd0,
      PH_PREHEAT = 3'd1,
      PH_IGNITE  = 3'd2,
      PH_BOOST   = 3'd3,
      PH_BURN    = 3'd4,
      PH_PWRDN   = 3'd5
   } phase_e;

endpackage

// File: rtl/lpt_cycle_count.sv
module lpt_cycle_count #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  logic         tick,
   output logic [W-1:0] count
);

   always_ff @(posedge clk) begin
      if (rst || clr)
         count <= '0;
      else if (tick)
         count <= count + 1'b1;
   end

   // R10: a phase change leaves the count at zero
   assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
      clr |=> (count == '0));

endmodule

// File: rtl/lpt_oc_window.sv
module lpt_oc_window #(
   parameter int OC_HALVES = 2,
   parameter int W         = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic arm,
   input  logic clr,
   input  logic oc,
   input  logic half,
   output logic expire
);

   localparam logic [W-1:0] LAST = W'(OC_HALVES - 1);

   logic [W-1:0] level;

   always_ff @(posedge clk) begin
      if (rst || clr || !arm || !oc)
         level <= '0;
      else if (half)
         level <= level + 1'b1;
   end

   assign expire = arm && oc && half && (level == LAST);

   // R8: a gap in the overcurrent empties the window
   assert_gap_clears_R8: assert property (@(posedge clk) disable iff (rst)
      !oc |=> (level == '0));

   // R7: the window never counts past its last mark
   assert_no_overrun_R7: assert property (@(posedge clk) disable iff (rst)
      level <= LAST);

endmodule

// File: rtl/lpt_phase_fsm.sv
module lpt_phase_fsm
   import lpt_pkg::*;
#(
   parameter int PRE_CYC   = 8,
   parameter int IGN_CYC   = 2,
   parameter int BOOST_CYC = 4,
   parameter int HW        = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [HW-1:0] hi_count,
   input  logic          saw,
   input  logic          supply_ok,
   input  logic          pin_high,
   input  logic          lamp_lit,
   input  logic          oc_expire,
   output phase_e        phase_q,
   output logic          phase_chg,
   output logic          tick_en,
   output logic          preheat_done,
   output logic          ign_fail,
   output logic          oc_fault
);

   localparam logic [HW-1:0] PRE_LAST = HW'(PRE_CYC - 1);
   localparam logic [HW-1:0] IGN_LAST = HW'(IGN_CYC - 1);
   localparam logic [HW-1:0] BST_LAST = HW'(BOOST_CYC - 1);

   phase_e nxt;
   logic   pd_set, if_set, of_set;

   always_comb begin
      nxt     = phase_q;
      pd_set  = 1'b0;
      if_set  = 1'b0;
      of_set  = 1'b0;
      tick_en = 1'b0;
      case (phase_q)
         PH_IDLE: begin
            if (supply_ok && pin_high) nxt = PH_PREHEAT;
         end
         PH_PREHEAT: begin
            tick_en = 1'b1;
            if (saw && hi_count == PRE_LAST) begin
               nxt    = PH_IGNITE;
               pd_set = 1'b1;
            end
         end
         PH_IGNITE: begin
            tick_en = 1'b1;
            if (lamp_lit)
               nxt = PH_BOOST;
            else if (saw && hi_count == IGN_LAST) begin
               nxt    = PH_PWRDN;
               if_set = 1'b1;
            end
         end
         PH_BOOST: begin
            tick_en = 1'b1;
            if (oc_expire) begin
               nxt    = PH_PWRDN;
               of_set = 1'b1;
            end else if (saw && hi_count == BST_LAST)
               nxt = PH_BURN;
         end
         PH_BURN: begin
            if (oc_expire) begin
               nxt    = PH_PWRDN;
               of_set = 1'b1;
            end
         end
         default: nxt = PH_PWRDN;
      endcase
   end

   assign phase_chg = (nxt != phase_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q      <= PH_IDLE;
         preheat_done <= 1'b0;
         ign_fail     <= 1'b0;
         oc_fault     <= 1'b0;
      end else begin
         phase_q      <= nxt;
         preheat_done <= pd_set;
         ign_fail     <= ign_fail | if_set;
         oc_fault     <= oc_fault | of_set;
      end
   end

   // R2: idle is left only with both start conditions present
   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
      (phase_q == PH_IDLE && !(supply_ok && pin_high)) |=> (phase_q == PH_IDLE));

   // R3: the strobe marks the preheat-to-ignite step only
   assert_strobe_R3: assert property (@(posedge clk) disable iff (rst)
      preheat_done |-> (phase_q == PH_IGNITE && $past(phase_q) == PH_PREHEAT));

   // R4: a strike in ignite always reaches boost
   assert_strike_R4: assert property (@(posedge clk) disable iff (rst)
      (phase_q == PH_IGNITE && lamp_lit) |=> (phase_q == PH_BOOST));

   // R5: an ignition fault comes only out of ignite into power-down
   assert_ign_fault_R5: assert property (@(posedge clk) disable iff (rst)
      $rose(ign_fail) |-> (phase_q == PH_PWRDN && $past(phase_q) == PH_IGNITE));

   // R7: an overcurrent fault lands in power-down
   assert_oc_fault_R7: assert property (@(posedge clk) disable iff (rst)
      $rose(oc_fault) |-> (phase_q == PH_PWRDN));

   // R9: power-down and the faults are sticky
   assert_pwrdn_sticky_R9: assert property (@(posedge clk) disable iff (rst)
      (phase_q == PH_PWRDN) |=> (phase_q == PH_PWRDN));
   assert_faults_latch_R9: assert property (@(posedge clk) disable iff (rst)
      (ign_fail || oc_fault) |=> ($stable(ign_fail) && $stable(oc_fault)));

endmodule

// File: rtl/lamp_phase_timer.sv
module lamp_phase_timer
   import lpt_pkg::*;
#(
   parameter int PRE_CYC     = 8,
   parameter int IGN_CYC     = 2,
   parameter int BOOST_CYC   = 4,
   parameter int OC_HALVES   = 2,
   parameter bit OC_IN_BOOST = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       saw_cycle,
   input  logic       saw_half,
   input  logic       supply_ok,
   input  logic       pin_high,
   input  logic       lamp_lit,
   input  logic       oc_cont,
   output logic [2:0] phase,
   output logic       preheat_done,
   output logic       ign_fail,
   output logic       oc_fault
);

   localparam int MAXC = (PRE_CYC > IGN_CYC)
                         ? ((PRE_CYC > BOOST_CYC) ? PRE_CYC : BOOST_CYC)
                         : ((IGN_CYC > BOOST_CYC) ? IGN_CYC : BOOST_CYC);
   localparam int HW   = (MAXC > 1) ? $clog2(MAXC) : 1;
   localparam int LW   = $clog2(OC_HALVES);

   if (PRE_CYC < 1 || IGN_CYC < 1 || BOOST_CYC < 1) begin : g_bad_cycles
      $error("lamp_phase_timer: phase cycle budgets must be at least 1");
   end
   if (OC_HALVES < 2) begin : g_bad_window
      $error("lamp_phase_timer: overcurrent window must exceed half a cycle");
   end

   phase_e         phase_q;
   logic           phase_chg, tick_en, oc_arm, oc_expire;
   logic [HW-1:0]  hi_count;

   if (OC_IN_BOOST) begin : g_oc_boost_burn
      assign oc_arm = (phase_q == PH_BOOST) || (phase_q == PH_BURN);
   end else begin : g_oc_burn_only
      assign oc_arm = (phase_q == PH_BURN);
   end

   lpt_cycle_count #(.W(HW)) u_count (
      .clk   (clk),
      .rst   (rst),
      .clr   (phase_chg),
      .tick  (saw_cycle && tick_en),
      .count (hi_count)
   );

   lpt_oc_window #(.OC_HALVES(OC_HALVES), .W(LW)) u_ocwin (
      .clk    (clk),
      .rst    (rst),
      .arm    (oc_arm),
      .clr    (phase_chg),
      .oc     (oc_cont),
      .half   (saw_half),
      .expire (oc_expire)
   );

   lpt_phase_fsm #(
      .PRE_CYC   (PRE_CYC),
      .IGN_CYC   (IGN_CYC),
      .BOOST_CYC (BOOST_CYC),
      .HW        (HW)
   ) u_fsm (
      .clk          (clk),
      .rst          (rst),
      .hi_count     (hi_count),
      .saw          (saw_cycle),
      .supply_ok    (supply_ok),
      .pin_high     (pin_high),
      .lamp_lit     (lamp_lit),
      .oc_expire    (oc_expire),
      .phase_q      (phase_q),
      .phase_chg    (phase_chg),
      .tick_en      (tick_en),
      .preheat_done (preheat_done),
      .ign_fail     (ign_fail),
      .oc_fault     (oc_fault)
   );

   assign phase = phase_q;

   // R10: the shared count stays inside the largest budget
   assert_count_range_R10: assert property (@(posedge clk) disable iff (rst)
      hi_count <= HW'(MAXC - 1));

   // R1: reset returns to idle with quiet outputs
   assert_reset_state_R1: assert property (@(posedge clk)
      rst |=> (phase == 3'd0 && !preheat_done && !ign_fail && !oc_fault));

endmodule

// File: tb/sim_lamp_phase_timer.sv
module sim_lamp_phase_timer;

   localparam int CLK_PERIOD = 10;

   localparam logic [5:0] S  = 6'b100000;
   localparam logic [5:0] H  = 6'b010000;
   localparam logic [5:0] OK = 6'b001000;
   localparam logic [5:0] PN = 6'b000100;
   localparam logic [5:0] L  = 6'b000010;
   localparam logic [5:0] O  = 6'b000001;
   localparam logic [5:0] NONE = 6'b000000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic saw_cycle = 0, saw_half = 0, supply_ok = 0, pin_high = 0;
   logic lamp_lit = 0, oc_cont = 0;
   logic [2:0] phase;
   logic preheat_done, ign_fail, oc_fault;

   int compared = 0;
   int mismatched = 0;
   bit done = 0;

   logic [5:0] exp_q[$];
   string      tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   lamp_phase_timer u0 (
      .clk(clk), .rst(rst), .saw_cycle(saw_cycle), .saw_half(saw_half),
      .supply_ok(supply_ok), .pin_high(pin_high), .lamp_lit(lamp_lit),
      .oc_cont(oc_cont), .phase(phase), .preheat_done(preheat_done),
      .ign_fail(ign_fail), .oc_fault(oc_fault)
   );

   function automatic logic [5:0] e(input logic [2:0] ph, input logic pd,
                                    input logic ig, input logic oc);
      return {ph, pd, ig, oc};
   endfunction

   task automatic drive(input logic [5:0] v);
      {saw_cycle, saw_half, supply_ok, pin_high, lamp_lit, oc_cont} = v;
   endtask

   task automatic cyc(input logic [5:0] v, input logic [5:0] ex, input string tag);
      @(negedge clk);
      rst = 1'b0;
      drive(v);
      exp_q.push_back(ex);
      tag_q.push_back(tag);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      drive(NONE);
      exp_q.push_back(e(3'd0, 0, 0, 0));
      tag_q.push_back("R1");
   endtask

   task automatic run_preheat();
      cyc(OK | PN, e(3'd1, 0, 0, 0), "R2");
      for (int i = 0; i < 7; i++) begin
         cyc(S, e(3'd1, 0, 0, 0), "R3");
         cyc(H, e(3'd1, 0, 0, 0), "R3");
      end
      cyc(S, e(3'd2, 1, 0, 0), "R3");
      cyc(NONE, e(3'd2, 0, 0, 0), "R3");
   endtask

   // monitor: compares one queued item per cycle after the edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            logic [5:0] ex;
            logic [5:0] act;
            string      tg;
            ex  = exp_q.pop_front();
            tg  = tag_q.pop_front();
            act = {phase, preheat_done, ign_fail, oc_fault};
            compared++;
            if (act !== ex) begin
               mismatched++;
               $display("FAIL %s: {phase,pd,ign,oc} actual=%b_%b expected=%b_%b",
                        tg, act[5:3], act[2:0], ex[5:3], ex[2:0]);
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         mismatched++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      // Case A: idle gating, preheat length, ignition failure, sticky power-down
      do_reset();
      cyc(S, e(3'd0, 0, 0, 0), "R2");
      cyc(OK | S, e(3'd0, 0, 0, 0), "R2");
      cyc(PN | S, e(3'd0, 0, 0, 0), "R2");
      run_preheat();
      cyc(S, e(3'd2, 0, 0, 0), "R10");
      cyc(S, e(3'd5, 0, 1, 0), "R5");
      for (int i = 0; i < 3; i++)
         cyc(S | H | OK | PN | L | O, e(3'd5, 0, 1, 0), "R9");

      // Case B: strike priority, overcurrent gaps, boost length, burn fault
      do_reset();
      run_preheat();
      cyc(S, e(3'd2, 0, 0, 0), "R4");
      cyc(S | L, e(3'd3, 0, 0, 0), "R4");
      cyc(O | H, e(3'd3, 0, 0, 0), "R8");
      cyc(NONE, e(3'd3, 0, 0, 0), "R8");
      cyc(O | H, e(3'd3, 0, 0, 0), "R8");
      cyc(S, e(3'd3, 0, 0, 0), "R6");
      cyc(S, e(3'd3, 0, 0, 0), "R6");
      cyc(S, e(3'd3, 0, 0, 0), "R6");
      cyc(O | H, e(3'd3, 0, 0, 0), "R6");
      cyc(O | S, e(3'd4, 0, 0, 0), "R6");
      cyc(H, e(3'd4, 0, 0, 0), "R7");
      cyc(O | H, e(3'd4, 0, 0, 0), "R10");
      cyc(O | S, e(3'd4, 0, 0, 0), "R7");
      cyc(O | H, e(3'd5, 0, 0, 1), "R7");
      cyc(S | H | L | O, e(3'd5, 0, 0, 1), "R9");

      // Case C: overcurrent window armed during boost
      do_reset();
      run_preheat();
      cyc(L, e(3'd3, 0, 0, 0), "R4");
      cyc(O | H, e(3'd3, 0, 0, 0), "R11");
      cyc(O | H, e(3'd5, 0, 0, 1), "R11");
      cyc(NONE, e(3'd5, 0, 0, 1), "R9");

      @(negedge clk);
      drive(NONE);
      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         mismatched++;
         $display("FAIL queue: actual=%0d left expected=0 left", exp_q.size());
      end
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

endmodule